// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a 16-bit timer. It watches the count value of a free-running counter that lives outside it. In capture mode it records the count when a chosen edge appears on its capture source. That source is either an external pin, passed through a synchronizer, or an internal event line that is already synchronous. In compare mode it drives a channel output pin. The output changes on matches between the count and the channel's own value, on the counter-at-zero strobe, and on a match strobe from the timer's reference channel 0.

Software reaches the channel through a byte-wide port with four addresses:

| Address | Use |
|---|---|
| 0 | Control byte |
| 1 | Low byte of the value |
| 2 | High byte of the value |
| 3 | Pending status; writing bit 0 = 1 clears it |

A low-byte write waits in a holding register until the high byte arrives. A compare therefore never runs against a half-written value. A capture or a compare match sets a pending flag. The interrupt request is that flag gated by the enable bit.

Top module: `tmr_ccu`

## Requirements
- R1: After reset the control byte reads 0x40 (interrupt enable set, all else zero), the value reads 0x0000, ch_out is low, irq is low and the pending bit is 0.
- R2: The control byte written at address 0 reads back unchanged at address 0 and takes effect on the next cycle. Its fields are:
  - bit 7: capture source (1 = internal event)
  - bit 6: interrupt enable
  - bits 5:3: compare action
  - bit 2: mode (1 = compare, 0 = capture)
  - bits 1:0: capture edge
- R3: A write to address 1 changes neither cap_value nor the value read at address 1. A later write to address 2 loads the whole value, with the high byte from that write and the low byte from the held one.
- R4: In capture mode with the pin source, the edge code selects what captures: 00 nothing, 01 rising, 10 falling, 11 both. A pin change set up before edge k captures the count present at edge k+2 into cap_value and sets pending.
- R5: With capture source 1, the internal event line is edge-detected with a one-edge latency and the pin is ignored. With source 0, the event line is ignored.
- R6: In compare mode a match (count equals value) is acted on at the next edge. Action 000 drives ch_out high, 001 drives it low and 010 inverts it.
- R7: Action 011 drives ch_out high on a match while counting up, and low on a match while counting down or on the zero strobe. Action 100 does the opposite. A match takes priority over the zero strobe.
- R8: Action 101 drives ch_out low on the channel-0 strobe and high on a match. Action 110 drives it high on the channel-0 strobe and low on a match. The own match takes priority.
- R9: Action 111 leaves ch_out unchanged. In capture mode ch_out holds its level and a count equal to the value sets no pending flag.
- R10: A capture or a compare match sets pending, which reads as bit 0 of address 3. irq equals pending AND the enable bit. Writing 1 to bit 0 of address 3 clears pending, but a new event in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Current counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| cnt_zero | input | 1 | Strobe: counter is at zero |
| ch0_match | input | 1 | Strobe: reference channel 0 matched |
| cap_pin | input | 1 | Asynchronous external capture pin |
| cap_alt | input | 1 | Synchronous internal capture event line |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 control, 1 low, 2 high, 3 status/clear) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ch_out | output | 1 | Channel output pin level |
| irq | output | 1 | Interrupt request |
| cap_value | output | 16 | Current capture/compare value |

## Verification
Each result has a fixed latency, and the bench samples it at that point:
- Register writes, compare-driven ch_out changes, pending and irq appear one edge after their stimulus.
- A capture from the internal event line appears after one edge.
- A capture from the pin appears after the third edge, and holds the count from that edge.

Inputs are driven on the falling clock edge and outputs are read on the falling edge one cycle later. For pin captures the bench also reads the value one edge early, to confirm it has not yet moved. The random phases predict ch_out, irq and cap_value every cycle with bench functions and compare them at that same point.

// File: rtl/tmr_ccu_pkg.sv
package tmr_ccu_pkg;

   // compare action codes (bits 5:3 of the control byte)
   typedef enum logic [2:0] {
      ACT_SET     = 3'b000,
      ACT_CLR     = 3'b001,
      ACT_TOG     = 3'b010,
      ACT_UP_SET  = 3'b011,
      ACT_UP_CLR  = 3'b100,
      ACT_REF_CLR = 3'b101,
      ACT_REF_SET = 3'b110,
      ACT_NONE    = 3'b111
   } cmp_act_e;

   // capture edge codes (bits 1:0)
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } cap_edge_e;

   typedef struct packed {
      logic      src_alt;
      logic      ien;
      cmp_act_e  act;
      logic      cmp_mode;
      cap_edge_e edge_sel;
   } ctrl_t;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_VLO  = 2'd1;
   localparam logic [1:0] A_VHI  = 2'd2;
   localparam logic [1:0] A_STAT = 2'd3;

   localparam logic [7:0] CTRL_RESET = 8'h40;

endpackage

// File: rtl/ccu_sync.sv
module ccu_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   if (STAGES < 2) begin : g_bad_stages
      $error("ccu_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[i] <= 1'b0;
            else        sr[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[i] <= 1'b0;
            else        sr[i] <= sr[i-1];
         end
      end
   end

   assign q = sr[STAGES-1];

endmodule

// File: rtl/ccu_capture.sv
module ccu_capture
   import tmr_ccu_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit ALT_SYNC    = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  logic      alt,
   input  logic      src_alt,
   input  cap_edge_e edge_sel,
   input  logic      cmp_mode,
   output logic      cap_evt
);
   logic pin_s, alt_s;
   logic pin_prev, alt_prev;
   logic rise, fall;

   ccu_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
   );

   if (ALT_SYNC) begin : g_alt_sync
      ccu_sync #(.STAGES(SYNC_STAGES)) u_alt_sync (
         .clk(clk), .rst_n(rst_n), .d(alt), .q(alt_s)
      );
   end else begin : g_alt_direct
      assign alt_s = alt;
   end

   // separate history per source: switching source makes no false edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_prev <= 1'b0;
         alt_prev <= 1'b0;
      end else begin
         pin_prev <= pin_s;
         alt_prev <= alt_s;
      end
   end

   always_comb begin
      if (src_alt) begin
         rise = alt_s & ~alt_prev;
         fall = ~alt_s & alt_prev;
      end else begin
         rise = pin_s & ~pin_prev;
         fall = ~pin_s & pin_prev;
      end
   end

   always_comb begin
      cap_evt = 1'b0;
      if (!cmp_mode) begin
         case (edge_sel)
            EDGE_RISE: cap_evt = rise;
            EDGE_FALL: cap_evt = fall;
            EDGE_ANY:  cap_evt = rise | fall;
            default:   cap_evt = 1'b0;
         endcase
      end
   end

   // R5: the unselected source never causes a capture
   p_alt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_alt && $stable(alt_s)) |-> !cap_evt);
   p_pin_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_alt && $stable(pin_s)) |-> !cap_evt);

endmodule

// File: rtl/ccu_compare.sv
module ccu_compare
   import tmr_ccu_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             cmp_mode,
   input  cmp_act_e         act,
   input  logic             cnt_down,
   input  logic             cnt_zero,
   input  logic             ch0_match,
   output logic             match,
   output logic             ch_out
);
   logic out_nxt;

   assign match = cmp_mode && (cnt_val == cmp_val);

   always_comb begin
      out_nxt = ch_out;
      if (cmp_mode) begin
         case (act)
            ACT_SET:     if (match) out_nxt = 1'b1;
            ACT_CLR:     if (match) out_nxt = 1'b0;
            ACT_TOG:     if (match) out_nxt = ~ch_out;
            ACT_UP_SET: begin
               if (match)         out_nxt = ~cnt_down;
               else if (cnt_zero) out_nxt = 1'b0;
            end
            ACT_UP_CLR: begin
               if (match)         out_nxt = cnt_down;
               else if (cnt_zero) out_nxt = 1'b1;
            end
            ACT_REF_CLR: begin
               if (match)          out_nxt = 1'b1;
               else if (ch0_match) out_nxt = 1'b0;
            end
            ACT_REF_SET: begin
               if (match)          out_nxt = 1'b0;
               else if (ch0_match) out_nxt = 1'b1;
            end
            default: out_nxt = ch_out;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_out <= 1'b0;
      else        ch_out <= out_nxt;
   end

   p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_mode && act == ACT_SET && match) |=> ch_out);
   p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_mode && act == ACT_CLR && match) |=> !ch_out);
   p_tog_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_mode && act == ACT_TOG && match) |=> (ch_out != $past(ch_out)));
   p_updown_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_mode && act == ACT_UP_SET && match) |=> (ch_out == !$past(cnt_down)));
   p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_mode && act == ACT_UP_CLR && cnt_zero && !match) |=> ch_out);
   p_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_mode && act == ACT_REF_CLR && ch0_match && !match) |=> !ch_out);
   p_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_mode && act == ACT_NONE) |=> $stable(ch_out));
   p_capmode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_mode |=> $stable(ch_out));

endmodule

// File: rtl/ccu_regs.sv
module ccu_regs
   import tmr_ccu_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [7:0]       wr_data,
   input  logic             cap_evt,
   input  logic             match_evt,
   input  logic [CNT_W-1:0] cnt_val,
   output ctrl_t            ctrl,
   output logic [CNT_W-1:0] value,
   output logic             pending,
   output logic [7:0]       rd_data
);
   localparam int HI_W = CNT_W - 8;

   logic [7:0] lo_hold;
   logic       wr_ctrl, wr_lo, wr_hi, wr_clr;

   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_lo   = wr_en && (addr == A_VLO);
   assign wr_hi   = wr_en && (addr == A_VHI);
   assign wr_clr  = wr_en && (addr == A_STAT) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl <= ctrl_t'(CTRL_RESET);
      else if (wr_ctrl) ctrl <= ctrl_t'(wr_data);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lo_hold <= 8'h00;
      else if (wr_lo) lo_hold <= wr_data;
   end

   // capture has priority over a software commit in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       value <= '0;
      else if (cap_evt) value <= cnt_val;
      else if (wr_hi)   value <= {wr_data[HI_W-1:0], lo_hold};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pending <= 1'b0;
      else if (cap_evt || match_evt)  pending <= 1'b1;
      else if (wr_clr)                pending <= 1'b0;
   end

   always_comb begin
      case (addr)
         A_CTRL:  rd_data = ctrl;
         A_VLO:   rd_data = value[7:0];
         A_VHI:   rd_data = 8'(value[CNT_W-1:8]);
         default: rd_data = {7'd0, pending};
      endcase
   end

   p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(value) |-> $past(cap_evt || wr_hi));
   p_pend_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> $past(cap_evt || match_evt));
   p_pend_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !cap_evt && !match_evt) |=> !pending);

endmodule

// File: rtl/tmr_ccu.sv
module tmr_ccu
   import tmr_ccu_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit ALT_SYNC    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_down,
   input  logic             cnt_zero,
   input  logic             ch0_match,
   input  logic             cap_pin,
   input  logic             cap_alt,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   output logic             ch_out,
   output logic             irq,
   output logic [CNT_W-1:0] cap_value
);
   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
      $error("tmr_ccu: CNT_W must lie in 9..16 (two byte lanes)");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_ccu: SYNC_STAGES must be at least 2");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] value;
   logic             pending;
   logic             cap_evt;
   logic             match;

   ccu_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr), .addr(reg_addr), .wr_data(reg_wdata),
      .cap_evt(cap_evt), .match_evt(match), .cnt_val(cnt_val),
      .ctrl(ctrl), .value(value), .pending(pending), .rd_data(reg_rdata)
   );

   ccu_capture #(.SYNC_STAGES(SYNC_STAGES), .ALT_SYNC(ALT_SYNC)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .pin(cap_pin), .alt(cap_alt),
      .src_alt(ctrl.src_alt), .edge_sel(ctrl.edge_sel),
      .cmp_mode(ctrl.cmp_mode), .cap_evt(cap_evt)
   );

   ccu_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .cnt_val(cnt_val), .cmp_val(value),
      .cmp_mode(ctrl.cmp_mode), .act(ctrl.act),
      .cnt_down(cnt_down), .cnt_zero(cnt_zero), .ch0_match(ch0_match),
      .match(match), .ch_out(ch_out)
   );

   assign irq       = pending & ctrl.ien;
   assign cap_value = value;

   // R10: the request never shows while the flag is clear
   p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pending);

endmodule

// File: tb/tb_tmr_ccu.sv
`timescale 1ns/1ps
module tb_tmr_ccu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_val = 16'd100;
   logic        cnt_down = 1'b0, cnt_zero = 1'b0, ch0_match = 1'b0;
   logic        cap_pin = 1'b0, cap_alt = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        ch_out, irq;
   logic [15:0] cap_value;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   tmr_ccu dut (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
      .cnt_zero(cnt_zero), .ch0_match(ch0_match), .cap_pin(cap_pin),
      .cap_alt(cap_alt), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_out(ch_out),
      .irq(irq), .cap_value(cap_value)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic park();
      cnt_val = 16'd100; cnt_down = 1'b0; cnt_zero = 1'b0; ch0_match = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] c, input logic dn, input logic z, input logic c0);
      cnt_val = c; cnt_down = dn; cnt_zero = z; ch0_match = c0;
      step();
      park();
   endtask

   // pin change, then count base, base+1, base+2 on successive cycles
   task automatic pin_cap(input logic lvl, input logic [15:0] base,
                          input logic [15:0] old_v, input logic [15:0] exp_v,
                          input string tag);
      cap_pin = lvl; cnt_val = base;
      step();
      cnt_val = base + 16'd1;
      step();
      chk({tag, " early"}, cap_value, old_v);
      cnt_val = base + 16'd2;
      step();
      chk(tag, cap_value, exp_v);
      park();
   endtask

   function automatic logic next_out(input logic [2:0] act, input logic m,
                                     input logic dn, input logic z,
                                     input logic c0, input logic cur);
      case (act)
         3'd0: return m ? 1'b1 : cur;
         3'd1: return m ? 1'b0 : cur;
         3'd2: return m ? ~cur : cur;
         3'd3: return m ? ~dn : (z ? 1'b0 : cur);
         3'd4: return m ? dn : (z ? 1'b1 : cur);
         3'd5: return m ? 1'b1 : (c0 ? 1'b0 : cur);
         3'd6: return m ? 1'b0 : (c0 ? 1'b1 : cur);
         default: return cur;
      endcase
   endfunction

   initial begin
      #(20ns * 150000);
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic [7:0]  d;
      logic        exp_out;
      logic        pend;
      logic [15:0] exp_val;
      logic        prev_alt;
      void'($urandom(32'd4242));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, d); chk("R1 ctrl", d, 8'h40);
      rd(2'd1, d); chk("R1 lo", d, 8'h00);
      rd(2'd2, d); chk("R1 hi", d, 8'h00);
      rd(2'd3, d); chk("R1 pend", d, 8'h00);
      chk("R1 ch_out", ch_out, 1'b0);
      chk("R1 irq", irq, 1'b0);
      chk("R1 cap_value", cap_value, 16'h0000);

      // R2 control readback
      wr(2'd0, 8'hA5); rd(2'd0, d); chk("R2 ctrl A5", d, 8'hA5);
      wr(2'd0, 8'h40); rd(2'd0, d); chk("R2 ctrl 40", d, 8'h40);

      // R3 buffered low byte
      wr(2'd1, 8'h34);
      chk("R3 lo held", cap_value, 16'h0000);
      rd(2'd1, d); chk("R3 lo read held", d, 8'h00);
      wr(2'd2, 8'h12);
      chk("R3 commit", cap_value, 16'h1234);
      rd(2'd1, d); chk("R3 lo read", d, 8'h34);
      rd(2'd2, d); chk("R3 hi read", d, 8'h12);
      wr(2'd1, 8'h05); wr(2'd2, 8'h00);

      // R6 set / clear / toggle
      wr(2'd0, 8'h44);
      pulse(16'd5, 0, 0, 0);
      chk("R6 set", ch_out, 1'b1);
      chk("R10 irq on match", irq, 1'b1);
      rd(2'd3, d); chk("R10 pend read", d, 8'h01);
      wr(2'd3, 8'h01); chk("R10 clear", irq, 1'b0);
      wr(2'd0, 8'h4C); pulse(16'd5, 0, 0, 0); chk("R6 clear", ch_out, 1'b0);
      wr(2'd0, 8'h54); pulse(16'd5, 0, 0, 0); chk("R6 toggle 1", ch_out, 1'b1);
      pulse(16'd5, 0, 0, 0); chk("R6 toggle 2", ch_out, 1'b0);
      wr(2'd3, 8'h01);
      // R10 enable gating
      wr(2'd0, 8'h04); pulse(16'd5, 0, 0, 0);
      chk("R10 masked irq", irq, 1'b0);
      rd(2'd3, d); chk("R10 masked pend", d, 8'h01);
      wr(2'd0, 8'h44); chk("R10 unmask", irq, 1'b1);
      wr(2'd0, 8'h5C); wr(2'd3, 8'h01);

      // R7 up/down aware
      chk("R7 start", ch_out, 1'b1);  // code 000 match above drove it high
      pulse(16'd100, 0, 1, 0); chk("R7 011 zero", ch_out, 1'b0);
      pulse(16'd5, 0, 0, 0);   chk("R7 011 up", ch_out, 1'b1);
      pulse(16'd5, 1, 0, 0);   chk("R7 011 down", ch_out, 1'b0);
      pulse(16'd5, 0, 1, 0);   chk("R7 011 match beats zero", ch_out, 1'b1);
      wr(2'd0, 8'h64);
      pulse(16'd100, 0, 1, 0); chk("R7 100 zero", ch_out, 1'b1);
      pulse(16'd5, 0, 0, 0);   chk("R7 100 up", ch_out, 1'b0);
      pulse(16'd5, 1, 0, 0);   chk("R7 100 down", ch_out, 1'b1);

      // R8 reference-channel actions
      wr(2'd0, 8'h6C);
      pulse(16'd100, 0, 0, 1); chk("R8 101 ch0", ch_out, 1'b0);
      pulse(16'd5, 0, 0, 0);   chk("R8 101 match", ch_out, 1'b1);
      wr(2'd0, 8'h74);
      pulse(16'd5, 0, 0, 1);   chk("R8 110 match wins", ch_out, 1'b0);
      pulse(16'd100, 0, 0, 1); chk("R8 110 ch0", ch_out, 1'b1);

      // R9 no-op action and capture-mode hold
      wr(2'd0, 8'h7C);
      pulse(16'd5, 1, 1, 1); chk("R9 111 hold", ch_out, 1'b1);
      wr(2'd0, 8'h40); wr(2'd3, 8'h01);
      pulse(16'd5, 0, 1, 1); chk("R9 capture hold", ch_out, 1'b1);
      rd(2'd3, d); chk("R9 no match pend", d, 8'h00);

      // R4 pin capture edge codes
      wr(2'd0, 8'h41);
      pin_cap(1'b1, 16'd200, 16'd5, 16'd202, "R4 rise");
      chk("R4 irq", irq, 1'b1);
      wr(2'd3, 8'h01);
      pin_cap(1'b0, 16'd300, 16'd202, 16'd202, "R4 fall ignored");
      rd(2'd3, d); chk("R4 no pend", d, 8'h00);
      wr(2'd0, 8'h42);
      pin_cap(1'b1, 16'd230, 16'd202, 16'd202, "R4 rise ignored");
      pin_cap(1'b0, 16'd210, 16'd202, 16'd212, "R4 fall");
      wr(2'd0, 8'h43);
      pin_cap(1'b1, 16'd220, 16'd212, 16'd222, "R4 any rise");
      pin_cap(1'b0, 16'd240, 16'd222, 16'd242, "R4 any fall");
      wr(2'd0, 8'h40);
      pin_cap(1'b1, 16'd250, 16'd242, 16'd242, "R4 off");
      pin_cap(1'b0, 16'd260, 16'd242, 16'd242, "R4 off 2");

      // R5 internal event source
      wr(2'd0, 8'hC1);
      cap_alt = 1'b1; cnt_val = 16'd400; step();
      chk("R5 alt rise", cap_value, 16'd400);
      cap_alt = 1'b0; cnt_val = 16'd410; step();
      chk("R5 alt fall ignored", cap_value, 16'd400);
      pin_cap(1'b1, 16'd500, 16'd400, 16'd400, "R5 pin ignored");
      step(); chk("R5 pin ignored late", cap_value, 16'd400);
      wr(2'd0, 8'h41);
      cap_alt = 1'b1; cnt_val = 16'd420; step(); cap_alt = 1'b0; step();
      chk("R5 alt ignored on pin src", cap_value, 16'd400);
      park();

      // random compare segments (R6 R7 R8 R9 R10)
      exp_out = 1'b1;
      for (int s = 0; s < 24; s++) begin
         logic [2:0]  act;
         logic        ien;
         logic [15:0] cmpv;
         act  = 3'($urandom % 8);
         ien  = 1'($urandom % 2);
         cmpv = 16'($urandom % 8);
         wr(2'd1, cmpv[7:0]); wr(2'd2, 8'h00);
         wr(2'd0, {1'b0, ien, act, 1'b1, 2'b00});
         wr(2'd3, 8'h01);
         pend = 1'b0;
         for (int c = 0; c < 50; c++) begin
            logic m;
            cnt_val   = 16'($urandom % 8);
            cnt_down  = 1'($urandom % 2);
            cnt_zero  = ($urandom % 4) == 0;
            ch0_match = ($urandom % 4) == 0;
            m = (cnt_val == cmpv);
            exp_out = next_out(act, m, cnt_down, cnt_zero, ch0_match, exp_out);
            pend = pend | m;
            step();
            chk("R6/R7/R8/R9 random ch_out", ch_out, exp_out);
            chk("R10 random irq", irq, pend & ien);
         end
         park();
      end

      // random captures from the internal event, both edges (R5 R4 R10)
      wr(2'd0, 8'hC3);
      wr(2'd1, 8'h00); wr(2'd2, 8'h00);
      wr(2'd3, 8'h01);
      exp_val = 16'h0000; pend = 1'b0; prev_alt = cap_alt;
      for (int c = 0; c < 600; c++) begin
         cap_alt = 1'($urandom % 2);
         cnt_val = 16'($urandom);
         if (cap_alt != prev_alt) begin
            exp_val = cnt_val;
            pend = 1'b1;
         end
         prev_alt = cap_alt;
         step();
         chk("R5 random capture", cap_value, exp_val);
         chk("R10 random cap irq", irq, pend);
      end

      // R10 set beats clear in the same cycle
      reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h01;
      cap_alt = ~cap_alt; cnt_val = 16'hBEEF;
      step();
      reg_wr = 1'b0;
      rd(2'd3, d); chk("R10 set wins", d, 8'h01);
      chk("R5 capture with clear", cap_value, 16'hBEEF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule